// File: doc/BRIEF.md
# Down-Counting Timer with Shared Port Pins

A programmable down-counting timer whose input, output and interrupt-acknowledge signals borrow pins from a general-purpose port. For each shared pin, a select bit decides whether the pin carries the timer's alternate function or plain I/O. As plain I/O, its direction comes from the pin's own data-direction bit. Every pin that is not shared is always plain I/O.

The timer input pin has two uses. It can be an external clock, which is synchronized and counted on its rising edges. It can also be a run/halt gate, in which case the counter steps on every system clock while the pin is high. When the input pin is left as plain I/O, the counter steps on every system clock.

The counter loads its preload value when the enable rises. After that it counts down and reloads whenever a tick finds it at zero. The timer output pin carries either an active-low interrupt request, driven from a sticky zero flag, or a square wave. The square wave starts high and inverts on every reload. An active-low acknowledge pin or a status-clear strobe clears the flag.

Top module: `timer_pinshare`

## Requirements
- R1: After reset, `count` is 0 and `zero_flag` is 0. The square-wave state is high, so with the output pin shared in square mode, `pin_out[TOUT_PIN]` is 1.
- R2: On the first clock edge at which `timer_en` is high after being low, `count` takes the value of `preload`.
- R3: Each tick while enabled decrements `count` by one, except that a tick at 0 reloads `preload`. After n ticks the count is therefore `preload - (n mod (preload+1))`.
- R4: Clock mode (`tin_mode`=0, `alt_sel[0]`=1): each rising edge on `pin_in[TIN_PIN]` is one tick, seen after a two-flop synchronizer. Edges must be slower than half the system clock rate.
- R5: Gate mode (`tin_mode`=1, `alt_sel[0]`=1): the counter ticks on every system clock while the synchronized `pin_in[TIN_PIN]` is high, and holds while it is low.
- R6: With `alt_sel[0]`=0, the counter ticks on every system clock.
- R7: A tick at zero sets `zero_flag`, which then stays set until it is cleared.
- R8: `stat_clr`=1 clears `zero_flag`, and so does a synchronized low on `pin_in[ACK_PIN]` when `alt_sel[2]`=1. A zero event in the same cycle wins over a clear. With `alt_sel[2]`=0, the acknowledge pin has no effect.
- R9: Interrupt mode (`tout_mode`=0): the timer output is low exactly when `zero_flag` and `irq_en` are both 1.
- R10: Square mode (`tout_mode`=1): the timer output is set high on an enable rise and inverts on every reload from zero.
- R11: Pin control: a pin that is not shared takes `pin_oe`=`ddr` and `pin_out`=`gp_out`. A shared output pin takes `pin_oe`=1 and carries the timer output. Shared input pins take `pin_oe`=0 and `pin_out`=0. Select bits are bit 0 for the input pin, bit 1 for the output pin and bit 2 for the acknowledge pin.
- R12: `port_rd[i]` returns `gp_out[i]` for a plain-I/O pin whose `ddr` bit is 1, and returns `pin_in[i]` for every other pin.
- R13: While `timer_en` is low, `count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timer_en | input | 1 | Timer enable; a rising level loads the preload |
| tin_mode | input | 1 | 0 = external clock, 1 = run/halt gate |
| tout_mode | input | 1 | 0 = interrupt request, 1 = square wave |
| irq_en | input | 1 | Lets the zero flag drive the interrupt |
| stat_clr | input | 1 | Clears the zero flag |
| preload | input | CNT_W | Reload value |
| alt_sel | input | 3 | Alternate-function select: input, output, acknowledge |
| ddr | input | PIN_N | Direction per pin, 1 = output |
| gp_out | input | PIN_N | General-purpose output data |
| pin_in | input | PIN_N | Pin levels seen from outside |
| pin_out | output | PIN_N | Pin drive values |
| pin_oe | output | PIN_N | Pin output enables |
| port_rd | output | PIN_N | Port read-back value |
| count | output | CNT_W | Current counter value |
| zero_flag | output | 1 | Sticky zero status |

## Verification
The assertions check on every cycle that a zero event reloads the preload, sets the flag and inverts the square wave. They also check that the flag stays set until a clear, that the counter holds while disabled or while the gate is low, that a synchronized edge lasts one cycle, and that the interrupt pin follows the flag. Only the bench scenarios can show the counts reached after a number of external edges or gate-high cycles, including the synchronizer latency. The same holds for the preload-zero corner, for an acknowledge pin that is ignored while left as plain I/O, and for the read-back and direction muxing under random port values.

// File: rtl/tpin_pkg.sv
package tpin_pkg;
  typedef enum logic {SRC_EDGE = 1'b0, SRC_GATE = 1'b1} tin_mode_e;
  typedef enum logic {OUT_IRQ = 1'b0, OUT_SQUARE = 1'b1} tout_mode_e;
  localparam int ALT_TIN  = 0;
  localparam int ALT_TOUT = 1;
  localparam int ALT_ACK  = 2;
endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
      s3 <= RST_VAL;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~s3;

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tpin_core.sv
module tpin_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             sq,
  output logic             zero_evt,
  output logic             en_rise
);
  logic en_q;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                   input logic [CNT_W-1:0] p);
    return (c == '0) ? p : c - 1'b1;
  endfunction

  assign en_rise  = en & ~en_q;
  assign zero_evt = en & en_q & tick & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cnt  <= '0;
      sq   <= 1'b1;
      flag <= 1'b0;
    end else begin
      en_q <= en;
      if (en_rise) begin
        cnt <= preload;
        sq  <= 1'b1;
      end else if (en && tick) begin
        cnt <= next_count(cnt, preload);
        if (zero_evt) sq <= ~sq;
      end
      if (zero_evt)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
    end
  end

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> cnt == $past(preload));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> flag);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R10
  sq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> sq != $past(sq));
  // R13
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/tpin_mux.sv
module tpin_mux #(
  parameter int PIN_N    = 8,
  parameter int TIN_PIN  = 3,
  parameter int TOUT_PIN = 4,
  parameter int ACK_PIN  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       alt_sel,
  input  logic             tout,
  input  logic [PIN_N-1:0] ddr,
  input  logic [PIN_N-1:0] gp_out,
  input  logic [PIN_N-1:0] pin_in,
  output logic [PIN_N-1:0] pin_out,
  output logic [PIN_N-1:0] pin_oe,
  output logic [PIN_N-1:0] port_rd
);
  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    localparam bit IS_TIN  = (i == TIN_PIN);
    localparam bit IS_TOUT = (i == TOUT_PIN);
    localparam bit IS_ACK  = (i == ACK_PIN);
    logic alt_here;
    assign alt_here   = (IS_TIN  && alt_sel[tpin_pkg::ALT_TIN])
                      | (IS_TOUT && alt_sel[tpin_pkg::ALT_TOUT])
                      | (IS_ACK  && alt_sel[tpin_pkg::ALT_ACK]);
    assign pin_oe[i]  = alt_here ? IS_TOUT : ddr[i];
    assign pin_out[i] = alt_here ? (IS_TOUT & tout) : gp_out[i];
    assign port_rd[i] = (!alt_here && ddr[i]) ? gp_out[i] : pin_in[i];
  end

  // R11
  tin_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_sel[tpin_pkg::ALT_TIN] |-> !pin_oe[TIN_PIN]);
  // R11
  tout_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_sel[tpin_pkg::ALT_TOUT] |-> (pin_oe[TOUT_PIN] && pin_out[TOUT_PIN] == tout));
endmodule

// File: rtl/timer_pinshare.sv
module timer_pinshare #(
  parameter int CNT_W    = 16,
  parameter int PIN_N    = 8,
  parameter int TIN_PIN  = 3,
  parameter int TOUT_PIN = 4,
  parameter int ACK_PIN  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timer_en,
  input  logic             tin_mode,
  input  logic             tout_mode,
  input  logic             irq_en,
  input  logic             stat_clr,
  input  logic [CNT_W-1:0] preload,
  input  logic [2:0]       alt_sel,
  input  logic [PIN_N-1:0] ddr,
  input  logic [PIN_N-1:0] gp_out,
  input  logic [PIN_N-1:0] pin_in,
  output logic [PIN_N-1:0] pin_out,
  output logic [PIN_N-1:0] pin_oe,
  output logic [PIN_N-1:0] port_rd,
  output logic [CNT_W-1:0] count,
  output logic             zero_flag
);
  import tpin_pkg::*;

  tin_mode_e  src_mode;
  tout_mode_e out_mode;
  logic tin_lvl, tin_rise, ack_lvl, ack_rise_unused;
  logic tick, clr, sq, tout, zero_evt, en_rise;

  assign src_mode = tin_mode_e'(tin_mode);
  assign out_mode = tout_mode_e'(tout_mode);

  tpin_sync #(.RST_VAL(1'b0)) u_tin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in[TIN_PIN]),
    .lvl(tin_lvl), .rise(tin_rise));

  tpin_sync #(.RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in[ACK_PIN]),
    .lvl(ack_lvl), .rise(ack_rise_unused));

  always_comb begin
    if (!alt_sel[ALT_TIN])          tick = 1'b1;
    else if (src_mode == SRC_GATE)  tick = tin_lvl;
    else                            tick = tin_rise;
  end

  assign clr  = stat_clr | (alt_sel[ALT_ACK] & ~ack_lvl);
  assign tout = (out_mode == OUT_SQUARE) ? sq : ~(zero_flag & irq_en);

  tpin_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(timer_en), .tick(tick), .clr(clr),
    .preload(preload), .cnt(count), .flag(zero_flag), .sq(sq),
    .zero_evt(zero_evt), .en_rise(en_rise));

  tpin_mux #(.PIN_N(PIN_N), .TIN_PIN(TIN_PIN), .TOUT_PIN(TOUT_PIN), .ACK_PIN(ACK_PIN)) u_mux (
    .clk(clk), .rst_n(rst_n), .alt_sel(alt_sel), .tout(tout), .ddr(ddr),
    .gp_out(gp_out), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .port_rd(port_rd));

  // R5
  gate_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_sel[ALT_TIN] && src_mode == SRC_GATE && !tin_lvl && !en_rise) |=> $stable(count));
  // R9
  irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_sel[ALT_TOUT] && out_mode == OUT_IRQ && zero_flag && irq_en) |-> !pin_out[TOUT_PIN]);
  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> zero_flag);
endmodule

// File: tb/test_timer_pinshare.sv
module test_timer_pinshare;
  localparam int CW = 16, PN = 8, TI = 3, TO = 4, AK = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic timer_en = 0, tin_mode = 0, tout_mode = 1, irq_en = 0, stat_clr = 0;
  logic [CW-1:0] preload = '0;
  logic [2:0] alt_sel = 3'b010;
  logic [PN-1:0] ddr = '0, gp_out = '0, pin_in = 8'hF7;
  logic [PN-1:0] pin_out, pin_oe, port_rd;
  logic [CW-1:0] count;
  logic zero_flag;
  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  timer_pinshare i_timer_pinshare (
    .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .tin_mode(tin_mode),
    .tout_mode(tout_mode), .irq_en(irq_en), .stat_clr(stat_clr),
    .preload(preload), .alt_sel(alt_sel), .ddr(ddr), .gp_out(gp_out),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .port_rd(port_rd),
    .count(count), .zero_flag(zero_flag));

  function automatic int exp_cnt(int p, int n);
    return p - (n % (p + 1));
  endfunction
  function automatic int exp_wraps(int p, int n);
    return n / (p + 1);
  endfunction
  function automatic logic [PN-1:0] exp_oe(logic [2:0] a, logic [PN-1:0] d);
    logic [PN-1:0] r = d;
    if (a[0]) r[TI] = 1'b0;
    if (a[1]) r[TO] = 1'b1;
    if (a[2]) r[AK] = 1'b0;
    return r;
  endfunction
  function automatic logic [PN-1:0] exp_rd(logic [2:0] a, logic [PN-1:0] d,
                                           logic [PN-1:0] g, logic [PN-1:0] p);
    logic [PN-1:0] m = d;
    if (a[0]) m[TI] = 1'b0;
    if (a[1]) m[TO] = 1'b0;
    if (a[2]) m[AK] = 1'b0;
    return (g & m) | (p & ~m);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(int p);
    preload = CW'(p);
    @(negedge clk) timer_en = 0; stat_clr = 1;
    @(negedge clk) stat_clr = 0; timer_en = 1;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flag", zero_flag, 0);
    chk("R1 square high", pin_out[TO], 1);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R6 R10 internal ticking, including preload 0
    for (int it = 0; it < 8; it++) begin
      int p = (it == 0) ? 0 : int'($urandom_range(1, 20));
      int k = int'($urandom_range(1, 60));
      alt_sel = 3'b010; tout_mode = 1;
      start(p);
      chk("R2 load", count, p);
      repeat (k) @(negedge clk);
      chk("R3 R6 count", count, exp_cnt(p, k));
      chk("R7 flag", zero_flag, exp_wraps(p, k) > 0);
      chk("R10 square", pin_out[TO], (exp_wraps(p, k) % 2) == 0);
    end

    // R13 hold while disabled
    timer_en = 0;
    begin
      logic [CW-1:0] held;
      @(negedge clk) held = count;
      repeat (6) @(negedge clk);
      chk("R13 hold", count, held);
    end

    // R4 external clock edges
    for (int it = 0; it < 5; it++) begin
      int p = int'($urandom_range(1, 9));
      int n = int'($urandom_range(1, 25));
      alt_sel = 3'b011; tin_mode = 0; pin_in[TI] = 0;
      repeat (4) @(negedge clk);
      start(p);
      for (int e = 0; e < n; e++) begin
        pin_in[TI] = 1; repeat (3) @(negedge clk);
        pin_in[TI] = 0; repeat (3) @(negedge clk);
      end
      repeat (5) @(negedge clk);
      chk("R4 edge count", count, exp_cnt(p, n));
    end

    // R5 gate mode
    for (int it = 0; it < 5; it++) begin
      int p = int'($urandom_range(2, 15));
      int m = int'($urandom_range(1, 40));
      alt_sel = 3'b011; tin_mode = 1; pin_in[TI] = 0;
      repeat (4) @(negedge clk);
      start(p);
      repeat (5) @(negedge clk);
      chk("R5 halted", count, p);
      pin_in[TI] = 1; repeat (m) @(negedge clk);
      pin_in[TI] = 0; repeat (5) @(negedge clk);
      chk("R5 gated count", count, exp_cnt(p, m));
    end
    timer_en = 0;

    // R9 interrupt output
    alt_sel = 3'b010; tout_mode = 0; irq_en = 1;
    start(2);
    repeat (5) @(negedge clk);
    timer_en = 0;
    @(negedge clk);
    chk("R9 irq low", pin_out[TO], 0);
    irq_en = 0; #1;
    chk("R9 irq masked", pin_out[TO], 1);
    irq_en = 1;

    // R8 ack pin ignored as plain I/O, then effective as acknowledge
    pin_in[AK] = 0;
    repeat (5) @(negedge clk);
    chk("R8 ack ignored", zero_flag, 1);
    alt_sel = 3'b110;
    repeat (2) @(negedge clk);
    chk("R8 ack clears", zero_flag, 0);
    chk("R9 irq released", pin_out[TO], 1);
    alt_sel = 3'b010; pin_in[AK] = 1;
    repeat (3) @(negedge clk);

    // R8 status clear
    preload = 1;
    @(negedge clk) timer_en = 1;
    repeat (5) @(negedge clk);
    timer_en = 0;
    @(negedge clk);
    chk("R7 flag set", zero_flag, 1);
    stat_clr = 1; @(negedge clk) stat_clr = 0;
    chk("R8 stat clear", zero_flag, 0);

    // R11 R12 pin mux under random values
    for (int it = 0; it < 20; it++) begin
      alt_sel = 3'($urandom);
      ddr = 8'($urandom); gp_out = 8'($urandom); pin_in = 8'($urandom);
      tout_mode = 1;
      #1;
      chk("R11 oe", pin_oe, exp_oe(alt_sel, ddr));
      if (!alt_sel[1]) chk("R11 out", pin_out, gp_out & ~({PN{1'b0}} | (alt_sel[0] ? 8'h08 : 8'h00) | (alt_sel[2] ? 8'h20 : 8'h00)) | (gp_out & 8'h00));
      chk("R12 read", port_rd, exp_rd(alt_sel, ddr, gp_out, pin_in));
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule